// File: doc/BRIEF.md
# Clock Sync Error Level Monitor

This block watches the clock-correction results of a time-triggered bus node and decides whether the node counts as synchronized to its cluster. At the end of every odd cycle a correction strobe delivers the measured rate and offset corrections and a flag saying whether a correction could be computed at all. The block compares the magnitudes with configured limits and keeps a count of consecutive failed odd cycles. It also derives a two-bit error level: active, passive or halted.

Degradations and recoveries are not applied when they are detected. They take effect only at the network idle time strobe. The synchronized flag therefore moves only at idle time, or when the node is returned to configuration. A startup or reintegration module signals that the node may join normal operation. The flag is then raised at the next idle time, provided nothing forbids it.

Top module: `sync_health_monitor`

## Requirements
- R1: After reset, sync_o is 0, level_o is 2'b00 (active) and fail_cnt_o is 0.
- R2: On a cycle with corr_stb_i high, the failure counter rises by one (saturating at all ones) when corr_ok_i is 0, or when the magnitude of either correction exceeds its limit. Otherwise it returns to 0. The new value shows one cycle after the strobe.
- R3: sync_o and level_o change only in the cycle that follows an idle_stb_i or cfg_i cycle.
- R4: A join_req_i pulse raises sync_o at the next idle strobe when the level is active and no degradation applies.
- R5: A rate or offset limit violation seen on a valid correction is latched. At the next idle strobe it moves the level to passive (2'b01) and clears sync_o.
- R6: At an idle strobe, a failure count greater than pass_lim_i moves an active node to passive and clears sync_o.
- R7: At an idle strobe, a failure count greater than fatal_lim_i moves the level to halted (2'b10) and clears sync_o. Halted is then kept at every later idle strobe until cfg_i.
- R8: A passive node returns to active, with sync_o set, at an idle strobe where the failure count is 0 and no violation is latched.
- R9: cfg_i clears the level to active, sync_o to 0, the counter to 0, and any latched violation or join request, halted included.
- R10: The limit checks are strict. A correction magnitude equal to its limit passes, including for negative corrections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_i | input | 1 | Node is in configuration; clears all state |
| join_req_i | input | 1 | Startup or reintegration complete, request normal operation |
| corr_stb_i | input | 1 | Odd-cycle correction result valid |
| corr_ok_i | input | 1 | A correction could be computed |
| rate_corr_i | input | CORR_W | Signed rate correction |
| offs_corr_i | input | CORR_W | Signed offset correction |
| rate_lim_i | input | CORR_W | Maximum rate correction magnitude |
| offs_lim_i | input | CORR_W | Maximum offset correction magnitude |
| idle_stb_i | input | 1 | Network idle time strobe |
| pass_lim_i | input | CNT_W | Failed-cycle threshold for passive |
| fatal_lim_i | input | CNT_W | Failed-cycle threshold for halted |
| sync_o | output | 1 | Node synchronized to cluster |
| fail_cnt_o | output | CNT_W | Consecutive failed odd cycles |
| level_o | output | 2 | Error level: 00 active, 01 passive, 10 halted |

## Verification
The bench builds the block with CNT_W=3 and CORR_W=8. A three-bit counter lets counter saturation at 7 be reached in a few strobes, and it still leaves room for the passive threshold of 2 and the fatal threshold of 4 to be crossed one after the other. The 8-bit corrections allow exact boundary values (equal to the limit, one past it, negative) against limits of 20 and 10.

// File: rtl/sync_health_monitor.sv
module sync_health_monitor #(
  parameter int CORR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_i,
  input  logic                     join_req_i,
  input  logic                     corr_stb_i,
  input  logic                     corr_ok_i,
  input  logic signed [CORR_W-1:0] rate_corr_i,
  input  logic signed [CORR_W-1:0] offs_corr_i,
  input  logic [CORR_W-1:0]        rate_lim_i,
  input  logic [CORR_W-1:0]        offs_lim_i,
  input  logic                     idle_stb_i,
  input  logic [CNT_W-1:0]         pass_lim_i,
  input  logic [CNT_W-1:0]         fatal_lim_i,
  output logic                     sync_o,
  output logic [CNT_W-1:0]         fail_cnt_o,
  output logic [1:0]               level_o
);
  localparam logic [1:0]       LVL_ACT = 2'b00;
  localparam logic [1:0]       LVL_PAS = 2'b01;
  localparam logic [1:0]       LVL_HLT = 2'b10;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CORR_W-1:0] rate_mag, offs_mag;
  logic rate_bad, offs_bad, corr_fail, lim_bad;
  logic viol_pend, join_pend;
  logic [1:0] lvl_nxt;
  logic sync_nxt;

  assign rate_mag  = rate_corr_i[CORR_W-1] ? $unsigned(-rate_corr_i) : $unsigned(rate_corr_i);
  assign offs_mag  = offs_corr_i[CORR_W-1] ? $unsigned(-offs_corr_i) : $unsigned(offs_corr_i);
  assign rate_bad  = rate_mag > rate_lim_i;
  assign offs_bad  = offs_mag > offs_lim_i;
  assign lim_bad   = corr_ok_i & (rate_bad | offs_bad);
  assign corr_fail = ~corr_ok_i | lim_bad;

  always_comb begin
    lvl_nxt  = level_o;
    sync_nxt = sync_o;
    if (level_o != LVL_HLT) begin
      if (fail_cnt_o > fatal_lim_i) begin
        lvl_nxt  = LVL_HLT;
        sync_nxt = 1'b0;
      end else if (fail_cnt_o > pass_lim_i || viol_pend) begin
        lvl_nxt  = LVL_PAS;
        sync_nxt = 1'b0;
      end else if (level_o == LVL_PAS) begin
        if (fail_cnt_o == '0) begin
          lvl_nxt  = LVL_ACT;
          sync_nxt = 1'b1;
        end
      end else if (join_pend) begin
        sync_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_cnt_o <= '0;
      viol_pend  <= 1'b0;
      join_pend  <= 1'b0;
      level_o    <= LVL_ACT;
      sync_o     <= 1'b0;
    end else if (cfg_i) begin
      fail_cnt_o <= '0;
      viol_pend  <= 1'b0;
      join_pend  <= 1'b0;
      level_o    <= LVL_ACT;
      sync_o     <= 1'b0;
    end else begin
      if (idle_stb_i) begin
        level_o   <= lvl_nxt;
        sync_o    <= sync_nxt;
        viol_pend <= 1'b0;
        join_pend <= 1'b0;
      end
      if (join_req_i) join_pend <= 1'b1;
      if (corr_stb_i) begin
        if (!corr_fail)                fail_cnt_o <= '0;
        else if (fail_cnt_o != CNT_MAX) fail_cnt_o <= fail_cnt_o + 1'b1;
        if (lim_bad) viol_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_health_monitor_chk.sv
module sync_health_monitor_chk #(
  parameter int CORR_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_i,
  input logic              idle_stb_i,
  input logic              corr_stb_i,
  input logic              corr_ok_i,
  input logic              sync_o,
  input logic [CNT_W-1:0]  fail_cnt_o,
  input logic [1:0]        level_o
);
  p_sync_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_stb_i && !cfg_i) |=> $stable(sync_o));

  p_level_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_stb_i && !cfg_i) |=> $stable(level_o));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 2'b10 && !cfg_i) |=> level_o == 2'b10);

  p_legal_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'b11);

  p_sync_only_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> level_o == 2'b00);

  p_cfg_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i |=> (level_o == 2'b00 && !sync_o && fail_cnt_o == '0));

  p_nocorr_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_stb_i && !corr_ok_i && !cfg_i && fail_cnt_o != '1) |=> fail_cnt_o == $past(fail_cnt_o) + 1'b1);
endmodule

bind sync_health_monitor sync_health_monitor_chk #(.CORR_W(CORR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .idle_stb_i(idle_stb_i),
  .corr_stb_i(corr_stb_i), .corr_ok_i(corr_ok_i),
  .sync_o(sync_o), .fail_cnt_o(fail_cnt_o), .level_o(level_o));

// File: tb/sync_health_monitor_tb_top.sv
`timescale 1ns/1ps
module sync_health_monitor_tb_top;
  localparam int CORR_W = 8;
  localparam int CNT_W  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_i = 0, join_req_i = 0, corr_stb_i = 0, corr_ok_i = 0, idle_stb_i = 0;
  logic signed [CORR_W-1:0] rate_corr_i = '0, offs_corr_i = '0;
  logic [CORR_W-1:0] rate_lim_i = 8'd20, offs_lim_i = 8'd10;
  logic [CNT_W-1:0] pass_lim_i = 3'd2, fatal_lim_i = 3'd4;
  logic sync_o;
  logic [CNT_W-1:0] fail_cnt_o;
  logic [1:0] level_o;

  always #2.5 clk = ~clk;

  sync_health_monitor #(.CORR_W(CORR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .join_req_i(join_req_i),
    .corr_stb_i(corr_stb_i), .corr_ok_i(corr_ok_i),
    .rate_corr_i(rate_corr_i), .offs_corr_i(offs_corr_i),
    .rate_lim_i(rate_lim_i), .offs_lim_i(offs_lim_i), .idle_stb_i(idle_stb_i),
    .pass_lim_i(pass_lim_i), .fatal_lim_i(fatal_lim_i),
    .sync_o(sync_o), .fail_cnt_o(fail_cnt_o), .level_o(level_o));

  typedef struct {
    logic             s;
    logic [1:0]       l;
    logic [CNT_W-1:0] c;
    string            tag;
  } exp_t;

  exp_t sbq[$];
  event sample_ev;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state derived from the requirements
  logic m_sync = 0, m_pend = 0, m_join = 0;
  logic [1:0] m_lvl = 2'b00;
  logic [CNT_W-1:0] m_cnt = '0;

  task automatic push(string tag);
    exp_t e;
    e.s = m_sync; e.l = m_lvl; e.c = m_cnt; e.tag = tag;
    sbq.push_back(e);
    -> sample_ev;
  endtask

  task automatic finish_step(string tag);
    @(posedge clk);
    @(negedge clk);
    cfg_i = 0; join_req_i = 0; corr_stb_i = 0; idle_stb_i = 0;
    push(tag);
  endtask

  function automatic int mag(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic do_corr(bit ok, int rate, int offs, string tag);
    bit viol;
    corr_stb_i = 1; corr_ok_i = ok;
    rate_corr_i = CORR_W'(rate); offs_corr_i = CORR_W'(offs);
    viol = ok && (mag(rate) > 20 || mag(offs) > 10);
    if (!ok || viol) begin
      if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
    end else m_cnt = '0;
    if (viol) m_pend = 1;
    finish_step(tag);
  endtask

  task automatic do_idle(string tag);
    idle_stb_i = 1;
    if (m_lvl != 2'b10) begin
      if (m_cnt > 4) begin m_lvl = 2'b10; m_sync = 0; end
      else if (m_cnt > 2 || m_pend) begin m_lvl = 2'b01; m_sync = 0; end
      else if (m_lvl == 2'b01) begin
        if (m_cnt == 0) begin m_lvl = 2'b00; m_sync = 1; end
      end else if (m_join) m_sync = 1;
    end
    m_pend = 0; m_join = 0;
    finish_step(tag);
  endtask

  task automatic do_join(string tag);
    join_req_i = 1; m_join = 1;
    finish_step(tag);
  endtask

  task automatic do_cfg(string tag);
    cfg_i = 1;
    m_sync = 0; m_lvl = 2'b00; m_cnt = '0; m_pend = 0; m_join = 0;
    finish_step(tag);
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      #0.5;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_vec++;
        if (sync_o !== e.s || level_o !== e.l || fail_cnt_o !== e.c) begin
          n_bad++;
          $display("FAIL %s: got sync=%0b level=%0b cnt=%0d, expected sync=%0b level=%0b cnt=%0d",
                   e.tag, sync_o, level_o, fail_cnt_o, e.s, e.l, e.c);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    push("R1 reset state");
    do_join("R4 join has no immediate effect");
    do_corr(1, 5, 3, "R2 good correction keeps count 0");
    do_idle("R4 sync raised at idle");
    do_corr(1, 20, -10, "R10 magnitude equal to limit passes");
    do_corr(1, -21, 0, "R10 negative rate past limit fails");
    do_corr(1, 3, -11, "R5 offset violation, sync held until idle (R3)");
    do_idle("R5 passive after latched violation");
    do_corr(1, 0, 0, "R2 success clears counter");
    do_idle("R8 passive recovers to active with sync");
    do_corr(0, 0, 0, "R2 no correction counts");
    do_corr(0, 0, 0, "R2 no correction counts");
    do_corr(0, 0, 0, "R3 level unchanged between idles");
    do_idle("R6 count above passive threshold");
    do_corr(0, 0, 0, "R2 count 4");
    do_corr(0, 0, 0, "R2 count 5");
    do_idle("R7 count above fatal threshold halts");
    do_corr(1, 0, 0, "R2 clear in halted");
    do_join("R7 join ignored while halted");
    do_idle("R7 halted is sticky");
    for (int i = 0; i < 8; i++) do_corr(0, 0, 0, "R2 saturating count");
    do_cfg("R9 configuration clears all");
    do_join("R9 join after configuration");
    do_idle("R4 rejoin after configuration");
    do_corr(1, 0, 0, "R2 success after rejoin");
    done = 1;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule